// File: doc/BRIEF.md
# Card Column Capture with Link-Error Abort

This block sits between a polled serial link that carries a card reader's signals and a column FIFO. Each column of a card shows up as twelve latched row levels and a brief index marker. The marker is synchronized and stretched into a long pulse. The row word is not trusted while that pulse is high, because the rows may have been sampled before the remote latch settled. The held word is written into the FIFO in the cycle after the stretched pulse falls. By then the rows are certain to have been stable for a whole poll interval, and they are still inside the reader's data-valid time.

A watcher is armed only while the reader is delivering column data. If a poll in that window reports a link error, a column may have been lost. The watcher then ends the read: it stops all further writes and holds the FIFO's forced-full control so the consumer stops waiting. It also sets a feed-check latch, which is reported on the next feed attempt so that the card is read again. An errored poll never updates the held row word. No recovery path can empty the FIFO.

Top module: `colcap_top`

## Requirements
- R1: A rising edge on `idx_raw` passes a two-flop synchronizer and an edge detector, then starts a stretched pulse of `STRETCH_CYC` cycles. If `idx_raw` is raised just before clock edge k, the FIFO write appears after edge k+`STRETCH_CYC`+3.
- R2: A new marker edge that arrives while the stretched pulse is running reloads the counter. The two markers produce exactly one write, at the retriggered fall.
- R3: `fifo_wr` is a single-cycle pulse, issued only at the fall of the stretched pulse. `fifo_wdata` carries the held row word as it stood at the fall, so it includes good polls that arrived during the stretch.
- R4: A poll with `poll_err` high never changes the held row word.
- R5: Writes happen only while `col_window` is high. At most `COLS` writes are made per window opening, and the column count clears while `col_window` is low.
- R6: The watcher ignores link errors while `col_window` is low.
- R7: A poll error inside the window sets `read_abort` and `fifo_force_full` on the next cycle. No FIFO write occurs while they are set.
- R8: `feed_check` is high exactly when `feed_req` is high and the feed-check latch is set.
- R9: The abort state and the feed-check latch clear only on `rst` or `abort_ack`. `fifo_force_full` never falls otherwise, and the block has no way to empty the FIFO.
- R10: After reset, `fifo_wr`, `fifo_wdata`, `fifo_force_full`, `read_abort` and `feed_check` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_raw | input | 1 | Raw index marker, asynchronous |
| rows | input | 12 | Latched row levels delivered by a poll |
| poll_stb | input | 1 | One poll result is present this cycle |
| poll_err | input | 1 | The present poll had a link error |
| col_window | input | 1 | Reader is in its column-data phase |
| feed_req | input | 1 | A feed cycle is being attempted |
| abort_ack | input | 1 | Clears abort state and the feed-check latch |
| fifo_wr | output | 1 | Column FIFO write strobe |
| fifo_wdata | output | 12 | Column word to write |
| fifo_force_full | output | 1 | Forces the FIFO to report filled |
| read_abort | output | 1 | Read cycle ended by a link error |
| feed_check | output | 1 | Feed check reported to the feed cycle |

## Verification
A table of column patterns is run through the capture path. Plain polls with alternating bits and single-end bits show that every row reaches the FIFO in its own bit position. A good poll made during the stretch must replace the earlier word, which shows that sampling happens at the fall and not at the rise. A poll made with an error while the window is closed must leave the earlier word in place, which separates row gating from watcher gating. Directed cases then measure the exact write latency and cover a retrigger, the per-window column limit, a closed window, an abort with its hold, feed-check reporting, and the acknowledge and reset clears.

// File: rtl/colcap_pkg.sv
package colcap_pkg;
    localparam int ROWS = 12;

    typedef logic [ROWS-1:0] col_word_t;

    typedef struct packed {
        logic      stb;
        logic      err;
        col_word_t rows;
    } poll_t;

    function automatic logic poll_good(input poll_t p);
        return p.stb && !p.err;
    endfunction

    function automatic logic poll_bad(input poll_t p);
        return p.stb && p.err;
    endfunction
endpackage

// File: rtl/idx_stretch.sv
module idx_stretch #(
    parameter int STRETCH_CYC = 28000
) (
    input  logic clk,
    input  logic rst,
    input  logic idx_raw,
    output logic stretch_o,
    output logic fall_o
);
    localparam int CW = $clog2(STRETCH_CYC + 1);

    logic [2:0]    sync_q;
    logic          rise;
    logic [CW-1:0] cnt;
    logic          stretch_q;

    assign rise      = sync_q[1] && !sync_q[2];
    assign stretch_o = (cnt != '0);
    assign fall_o    = stretch_q && !stretch_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '0;
            cnt       <= '0;
            stretch_q <= 1'b0;
        end else begin
            sync_q    <= {sync_q[1:0], idx_raw};
            stretch_q <= stretch_o;
            if (rise)
                cnt <= CW'(STRETCH_CYC);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    AST_STRETCH_START: assert property (@(posedge clk) disable iff (rst)
        rise |=> stretch_o); // R1
    AST_FALL_ONE: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R3
endmodule

// File: rtl/err_watch.sv
module err_watch
    import colcap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  col_window,
    input  poll_t poll,
    input  logic  feed_req,
    input  logic  abort_ack,
    output logic  aborted,
    output logic  feed_check
);
    logic fc_latch;
    logic trip;

    assign trip       = col_window && poll_bad(poll);
    assign feed_check = feed_req && fc_latch;

    always_ff @(posedge clk) begin
        if (rst) begin
            aborted  <= 1'b0;
            fc_latch <= 1'b0;
        end else if (abort_ack) begin
            aborted  <= 1'b0;
            fc_latch <= 1'b0;
        end else if (trip) begin
            aborted  <= 1'b1;
            fc_latch <= 1'b1;
        end
    end

    AST_ABORT_SET: assert property (@(posedge clk) disable iff (rst)
        (col_window && poll.stb && poll.err && !abort_ack) |=> aborted); // R7
    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (aborted && !abort_ack) |=> aborted); // R9
    AST_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (!aborted && !col_window) |=> !aborted); // R6
    AST_FEED_REPORT: assert property (@(posedge clk) disable iff (rst)
        feed_check |-> feed_req); // R8
endmodule

// File: rtl/col_commit.sv
module col_commit
    import colcap_pkg::*;
#(
    parameter int COLS = 80
) (
    input  logic      clk,
    input  logic      rst,
    input  poll_t     poll,
    input  logic      fall,
    input  logic      col_window,
    input  logic      aborted,
    output logic      fifo_wr,
    output col_word_t fifo_wdata
);
    localparam int NW = $clog2(COLS + 1);

    col_word_t     held;
    logic [NW-1:0] ncol;

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= '0;
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
            ncol       <= '0;
        end else begin
            fifo_wr <= 1'b0;
            if (poll_good(poll))
                held <= poll.rows;
            if (!col_window) begin
                ncol <= '0;
            end else if (fall && !aborted && ncol < NW'(COLS)) begin
                fifo_wr    <= 1'b1;
                fifo_wdata <= held;
                ncol       <= ncol + 1'b1;
            end
        end
    end

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |=> !fifo_wr); // R3
    AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> ($past(col_window) && !$past(aborted))); // R5 R7
    AST_COL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ncol <= NW'(COLS)); // R5
endmodule

// File: rtl/colcap_top.sv
module colcap_top
    import colcap_pkg::*;
#(
    parameter int STRETCH_CYC = 28000,
    parameter int COLS        = 80
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            idx_raw,
    input  logic [ROWS-1:0] rows,
    input  logic            poll_stb,
    input  logic            poll_err,
    input  logic            col_window,
    input  logic            feed_req,
    input  logic            abort_ack,
    output logic            fifo_wr,
    output logic [ROWS-1:0] fifo_wdata,
    output logic            fifo_force_full,
    output logic            read_abort,
    output logic            feed_check
);
    poll_t poll;
    logic  stretch;
    logic  fall;
    logic  aborted;

    assign poll            = '{stb: poll_stb, err: poll_err, rows: rows};
    assign read_abort      = aborted;
    assign fifo_force_full = aborted;

    idx_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk(clk), .rst(rst), .idx_raw(idx_raw),
        .stretch_o(stretch), .fall_o(fall)
    );

    err_watch u_watch (
        .clk(clk), .rst(rst), .col_window(col_window), .poll(poll),
        .feed_req(feed_req), .abort_ack(abort_ack),
        .aborted(aborted), .feed_check(feed_check)
    );

    col_commit #(.COLS(COLS)) u_commit (
        .clk(clk), .rst(rst), .poll(poll), .fall(fall),
        .col_window(col_window), .aborted(aborted),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
    );

    AST_FULL_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        (fifo_force_full && !abort_ack) |=> fifo_force_full); // R9
    AST_NO_WR_ABORT: assert property (@(posedge clk) disable iff (rst)
        read_abort |=> !fifo_wr); // R7
endmodule

// File: tb/colcap_top_test.sv
module colcap_top_test;
    localparam int N    = 20;
    localparam int COLS = 3;

    logic        clk = 0;
    logic        rst = 1;
    logic        idx_raw = 0;
    logic [11:0] rows = '0;
    logic        poll_stb = 0, poll_err = 0, col_window = 0;
    logic        feed_req = 0, abort_ack = 0;
    logic        fifo_wr, fifo_force_full, read_abort, feed_check;
    logic [11:0] fifo_wdata;

    int errors = 0;
    int checks = 0;
    int nwr = 0;
    logic done = 0;

    colcap_top #(.STRETCH_CYC(N), .COLS(COLS)) uut (
        .clk(clk), .rst(rst), .idx_raw(idx_raw), .rows(rows),
        .poll_stb(poll_stb), .poll_err(poll_err), .col_window(col_window),
        .feed_req(feed_req), .abort_ack(abort_ack),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_force_full(fifo_force_full), .read_abort(read_abort),
        .feed_check(feed_check)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (!rst && fifo_wr) nwr++;

    typedef struct packed {
        logic [11:0] pre_v;
        logic        pre_e;
        logic        mid_en;
        logic [11:0] mid_v;
        logic [11:0] exp_v;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{12'hA5A, 1'b0, 1'b0, 12'h000, 12'hA5A},
        '{12'h3C3, 1'b0, 1'b1, 12'h0F0, 12'h0F0},
        '{12'hFFF, 1'b1, 1'b0, 12'h000, 12'h0F0},
        '{12'h001, 1'b0, 1'b1, 12'h800, 12'h800},
        '{12'h555, 1'b0, 1'b0, 12'h000, 12'h555}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poll(input logic [11:0] v, input logic e);
        @(negedge clk);
        rows = v; poll_stb = 1; poll_err = e;
        @(negedge clk);
        poll_stb = 0; poll_err = 0;
    endtask

    // idx_raw rises before edge 1; optional good poll mid-stretch
    task automatic fire(input logic mid_en, input logic [11:0] mid_v,
                        output int lat, output logic [11:0] d);
        @(negedge clk);
        idx_raw = 1; lat = 0; d = '0;
        for (int i = 1; i <= 60; i++) begin
            @(posedge clk); #1;
            if (i == 3) idx_raw = 0;
            if (i == 6 && mid_en) begin rows = mid_v; poll_stb = 1; poll_err = 0; end
            if (i == 7) poll_stb = 0;
            if (fifo_wr && lat == 0) begin lat = i; d = fifo_wdata; end
        end
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat;
        logic [11:0] d;
        int base;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk("R10 wr", fifo_wr, 0);
        chk("R10 wdata", fifo_wdata, 0);
        chk("R10 full", fifo_force_full, 0);
        chk("R10 abort", read_abort, 0);
        feed_req = 1; @(negedge clk);
        chk("R10 feed_check", feed_check, 0);
        feed_req = 0;

        col_window = 1;
        foreach (VECS[k]) begin
            if (VECS[k].pre_e) begin
                col_window = 0;
                poll(VECS[k].pre_v, 1'b1);
                @(negedge clk);
                chk("R6 no abort outside window", read_abort, 0);
                col_window = 1;
            end else begin
                poll(VECS[k].pre_v, 1'b0);
            end
            fire(VECS[k].mid_en, VECS[k].mid_v, lat, d);
            chk("R1 latency", lat, N + 4);
            chk("R3 R4 data", d, VECS[k].exp_v);
        end

        // R5: limit reached (3 writes since window reopened)
        base = nwr;
        fire(1'b0, 12'h0, lat, d);
        chk("R5 column limit", nwr - base, 0);

        // R5: closed window, then reopen clears count
        col_window = 0;
        base = nwr;
        fire(1'b0, 12'h0, lat, d);
        chk("R5 closed window", nwr - base, 0);
        col_window = 1;
        fire(1'b0, 12'h0, lat, d);
        chk("R5 reopened write", lat, N + 4);

        // R2 retrigger
        base = nwr; lat = 0;
        @(negedge clk); idx_raw = 1;
        for (int i = 1; i <= 70; i++) begin
            @(posedge clk); #1;
            if (i == 3) idx_raw = 0;
            if (i == 8) idx_raw = 1;
            if (i == 11) idx_raw = 0;
            if (fifo_wr && lat == 0) lat = i;
        end
        chk("R2 single write", nwr - base, 1);
        chk("R2 retrigger time", lat, 9 + N + 3);

        // R7 abort in window
        col_window = 0; @(negedge clk); col_window = 1;
        poll(12'h123, 1'b1);
        chk("R7 abort", read_abort, 1);
        chk("R7 force full", fifo_force_full, 1);
        base = nwr;
        fire(1'b0, 12'h0, lat, d);
        chk("R7 no write aborted", nwr - base, 0);
        chk("R9 full held", fifo_force_full, 1);
        // R8
        chk("R8 feed_check idle", feed_check, 0);
        feed_req = 1; @(negedge clk);
        chk("R8 feed_check on", feed_check, 1);
        feed_req = 0; @(negedge clk);
        // R9 ack clears
        abort_ack = 1; @(negedge clk); abort_ack = 0;
        chk("R9 ack abort", read_abort, 0);
        chk("R9 ack full", fifo_force_full, 0);
        feed_req = 1; @(negedge clk);
        chk("R9 ack latch", feed_check, 0);
        feed_req = 0;
        // R9 reset clears
        poll(12'h0, 1'b1);
        chk("R7 abort again", read_abort, 1);
        rst = 1; @(negedge clk); rst = 0; @(negedge clk);
        chk("R9 rst abort", read_abort, 0);
        feed_req = 1; @(negedge clk);
        chk("R9 rst latch", feed_check, 0);
        feed_req = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule